// File: doc/BRIEF.md
# RTC Time Readout and Repair Sequencer

This block turns a raw serial real-time-clock chip into a source of checked calendar time. It sits above a master that performs one register access at a time on the serial wire. When the host pulses a request, the sequencer reads six time registers one after another and turns each packed BCD byte into a binary number. It then checks that every field lies inside its calendar range.

If all fields are in range, the decoded time is reported. If any field is out of range, the clock holds corrupt data. The block then writes a fixed default date back to the chip in a set order, with the seconds register written last so that the oscillator restarts. It reports midnight on 1 January of year 0 (meaning year 2000) and raises a repaired flag. The host sees a one-cycle done pulse when the fields and the flag are ready.

Top module: `rtc_time_fetch`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `acc_req_o`, `repaired_o` and all six time fields are 0 until the first request completes.
- R2: A request reads the registers with `acc_wr_o`=0 at addresses 0x00 (seconds), 0x01 (minutes), 0x02 (hours), 0x03 (day of month), 0x04 (month), 0x06 (year), in exactly that order, and the day-of-week register 0x05 is never read.
- R3: `acc_req_o` is a one-cycle pulse, and no new access is issued until the serial master has returned `acc_done_i` for the previous one.
- R4: Each byte is reported as (bits [7:4] times 10) plus bits [3:0]. For seconds only bits [6:0] are used, so the halt bit 7 does not change the value.
- R5: When seconds ≤ 59, minutes ≤ 59, hours ≤ 23, day of month is 1 to 31, month is 1 to 12 and year ≤ 99, the decoded values are reported, `repaired_o` is 0 and no write is issued.
- R6: When any field breaks R5, seven writes follow the reads, as (address, data) pairs in this order: (0x01,0x00), (0x02,0x00), (0x05,0x07), (0x03,0x01), (0x04,0x01), (0x06,0x00), (0x00,0x00). The seconds write is last and has bit 7 clear.
- R7: After a repair the reported fields are seconds 0, minutes 0, hours 0, day 1, month 1, year 0, and `repaired_o` is 1. The flag holds until the next request completes.
- R8: A `start_i` pulse that arrives while a request is in progress is ignored. It issues no extra access and produces no extra done pulse.
- R9: `done_o` is a one-cycle pulse. The time fields and `repaired_o` change only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a readout (pulse) |
| done_o | output | 1 | Readout finished, fields valid (pulse) |
| sec_o | output | 8 | Seconds, binary |
| min_o | output | 8 | Minutes, binary |
| hour_o | output | 8 | Hours, binary |
| mday_o | output | 8 | Day of month, binary |
| mon_o | output | 8 | Month, binary |
| year_o | output | 8 | Year within century, binary |
| repaired_o | output | 1 | Defaults were written back during the last request |
| acc_req_o | output | 1 | Access request pulse to the serial master |
| acc_wr_o | output | 1 | Access is a write |
| acc_addr_o | output | 6 | Register address of the access |
| acc_wdata_o | output | 8 | Write data of the access |
| acc_rdata_i | input | 8 | Read data, valid with acc_done_i |
| acc_done_i | input | 1 | Access complete (pulse) |

## Verification
The bench sweeps all 256 byte values through each of the six fields in turn, with the other fields held at their upper range limits. This covers every range edge and every nibble above nine. A design that compared against the wrong limit would repair a good time or let a bad one through. A design that kept the halt bit in the seconds value would report seconds above 79 or repair a clock that is only halted. The full access log of each request is compared against the expected one. A wrong write order, a write to the seconds register that is not last, or a stray read of the day-of-week register would show up there. A second start pulse during a busy request is checked for extra accesses or a second done pulse. The serial master's latency is varied, which exposes any access issued before the previous one completed.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = BYTE_W / 2;
  localparam int ADDR_W  = 6;
  localparam int NUM_FLD = 6;   // fields read: sec, min, hour, mday, mon, year
  localparam int NUM_WR  = 7;   // registers written on repair
  localparam int IDX_W   = $clog2(NUM_WR);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_CHECK, S_WR_REQ, S_WR_WAIT, S_FIN
  } seq_st_t;

  // chip address for the i-th read
  function automatic logic [ADDR_W-1:0] rd_addr(input logic [IDX_W-1:0] i);
    case (i)
      3'd5:    rd_addr = ADDR_W'(6);
      default: rd_addr = ADDR_W'(i);
    endcase
  endfunction

  // chip address for the i-th repair write; seconds come last
  function automatic logic [ADDR_W-1:0] wr_addr(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    wr_addr = ADDR_W'(1);
      3'd1:    wr_addr = ADDR_W'(2);
      3'd2:    wr_addr = ADDR_W'(5);
      3'd3:    wr_addr = ADDR_W'(3);
      3'd4:    wr_addr = ADDR_W'(4);
      3'd5:    wr_addr = ADDR_W'(6);
      default: wr_addr = ADDR_W'(0);
    endcase
  endfunction

  // BCD byte for the i-th repair write
  function automatic logic [BYTE_W-1:0] wr_data(input logic [IDX_W-1:0] i);
    case (i)
      3'd2:       wr_data = BYTE_W'(8'h07);
      3'd3, 3'd4: wr_data = BYTE_W'(8'h01);
      default:    wr_data = '0;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] fld_lo(input int k);
    fld_lo = (k == 3 || k == 4) ? BYTE_W'(1) : '0;
  endfunction

  function automatic logic [BYTE_W-1:0] fld_hi(input int k);
    case (k)
      0, 1:    fld_hi = BYTE_W'(59);
      2:       fld_hi = BYTE_W'(23);
      3:       fld_hi = BYTE_W'(31);
      4:       fld_hi = BYTE_W'(12);
      default: fld_hi = BYTE_W'(99);
    endcase
  endfunction

  // value reported after a repair equals each field's lower bound
  function automatic logic [BYTE_W-1:0] fld_dflt(input int k);
    fld_dflt = fld_lo(k);
  endfunction
endpackage

// File: rtl/rtcs_rst_sync.sv
module rtcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/rtcs_bcd_field.sv
module rtcs_bcd_field import rtcs_pkg::*; #(
  parameter bit DROP_TOP = 1'b0
) (
  input  logic [BYTE_W-1:0] raw_i,
  output logic [BYTE_W-1:0] bin_o
);
  logic [NIB_W-1:0] hi, lo;

  generate
    if (DROP_TOP) begin : g_drop
      assign hi = {1'b0, raw_i[BYTE_W-2:NIB_W]};
    end else begin : g_keep
      assign hi = raw_i[BYTE_W-1:NIB_W];
    end
  endgenerate

  assign lo = raw_i[NIB_W-1:0];
  // hi*10 = hi*8 + hi*2
  assign bin_o = {1'b0, hi, 3'b000} + {3'b000, hi, 1'b0} + {{NIB_W{1'b0}}, lo};
endmodule

// File: rtl/rtcs_range_chk.sv
module rtcs_range_chk import rtcs_pkg::*; (
  input  logic [NUM_FLD-1:0][BYTE_W-1:0] bin_i,
  output logic                           bad_o
);
  logic [NUM_FLD-1:0] oor;

  generate
    for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
      if (fld_lo(k) == 0) begin : g_hi_only
        assign oor[k] = bin_i[k] > fld_hi(k);
      end else begin : g_both
        assign oor[k] = (bin_i[k] < fld_lo(k)) || (bin_i[k] > fld_hi(k));
      end
    end
  endgenerate

  assign bad_o = |oor;
endmodule

// File: rtl/rtcs_seq.sv
module rtcs_seq import rtcs_pkg::*; (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           acc_done_i,
  input  logic [BYTE_W-1:0]              acc_rdata_i,
  input  logic                           bad_i,
  output logic                           acc_req_o,
  output logic                           acc_wr_o,
  output logic [ADDR_W-1:0]              acc_addr_o,
  output logic [BYTE_W-1:0]              acc_wdata_o,
  output logic [NUM_FLD-1:0][BYTE_W-1:0] raw_o,
  output logic                           latch_o,
  output logic                           dflt_o
);
  localparam logic [IDX_W-1:0] LAST_RD = IDX_W'(NUM_FLD - 1);
  localparam logic [IDX_W-1:0] LAST_WR = IDX_W'(NUM_WR - 1);

  seq_st_t          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             bad_q, bad_d;
  logic             cap_en;
  logic [NUM_FLD-1:0][BYTE_W-1:0] raw_q;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    bad_d  = bad_q;
    cap_en = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        st_d  = S_RD_REQ;
        idx_d = '0;
      end
      S_RD_REQ: st_d = S_RD_WAIT;
      S_RD_WAIT: if (acc_done_i) begin
        cap_en = 1'b1;
        if (idx_q == LAST_RD) st_d = S_CHECK;
        else begin
          idx_d = idx_q + 1'b1;
          st_d  = S_RD_REQ;
        end
      end
      S_CHECK: begin
        bad_d = bad_i;
        idx_d = '0;
        st_d  = bad_i ? S_WR_REQ : S_FIN;
      end
      S_WR_REQ: st_d = S_WR_WAIT;
      S_WR_WAIT: if (acc_done_i) begin
        if (idx_q == LAST_WR) st_d = S_FIN;
        else begin
          idx_d = idx_q + 1'b1;
          st_d  = S_WR_REQ;
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      bad_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      bad_q <= bad_d;
    end
  end

  generate
    for (genvar k = 0; k < NUM_FLD; k++) begin : g_raw
      logic slot_en;
      assign slot_en = cap_en && (idx_q == IDX_W'(k));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      raw_q[k] <= '0;
        else if (slot_en) raw_q[k] <= acc_rdata_i;
      end
    end
  endgenerate

  assign acc_req_o   = (st_q == S_RD_REQ) || (st_q == S_WR_REQ);
  assign acc_wr_o    = (st_q == S_WR_REQ);
  assign acc_addr_o  = acc_wr_o ? wr_addr(idx_q) : rd_addr(idx_q);
  assign acc_wdata_o = acc_wr_o ? wr_data(idx_q) : '0;
  assign raw_o       = raw_q;
  assign latch_o     = (st_q == S_FIN);
  assign dflt_o      = bad_q;
endmodule

// File: rtl/rtc_time_fetch.sv
module rtc_time_fetch import rtcs_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic [BYTE_W-1:0] mday_o,
  output logic [BYTE_W-1:0] mon_o,
  output logic [BYTE_W-1:0] year_o,
  output logic              repaired_o,
  output logic              acc_req_o,
  output logic              acc_wr_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [BYTE_W-1:0] acc_wdata_o,
  input  logic [BYTE_W-1:0] acc_rdata_i,
  input  logic              acc_done_i
);
  logic rst_sn;
  logic bad, latch, dflt;
  logic [NUM_FLD-1:0][BYTE_W-1:0] raw, bin, fld_d, fld_q;
  logic done_q, rep_q;

  rtcs_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sn)
  );

  rtcs_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_sn), .start_i(start_i),
    .acc_done_i(acc_done_i), .acc_rdata_i(acc_rdata_i), .bad_i(bad),
    .acc_req_o(acc_req_o), .acc_wr_o(acc_wr_o), .acc_addr_o(acc_addr_o),
    .acc_wdata_o(acc_wdata_o), .raw_o(raw), .latch_o(latch), .dflt_o(dflt)
  );

  generate
    for (genvar k = 0; k < NUM_FLD; k++) begin : g_dec
      rtcs_bcd_field #(.DROP_TOP(k == 0)) u_bcd (.raw_i(raw[k]), .bin_o(bin[k]));
      assign fld_d[k] = dflt ? fld_dflt(k) : bin[k];
    end
  endgenerate

  rtcs_range_chk u_rng (.bin_i(bin), .bad_o(bad));

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      fld_q  <= '0;
      rep_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= latch;
      if (latch) begin
        fld_q <= fld_d;
        rep_q <= dflt;
      end
    end
  end

  assign done_o     = done_q;
  assign repaired_o = rep_q;
  assign sec_o      = fld_q[0];
  assign min_o      = fld_q[1];
  assign hour_o     = fld_q[2];
  assign mday_o     = fld_q[3];
  assign mon_o      = fld_q[4];
  assign year_o     = fld_q[5];
endmodule

// File: rtl/rtcs_chk.sv
module rtcs_chk import rtcs_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [BYTE_W-1:0] sec_o,
  input logic [BYTE_W-1:0] min_o,
  input logic [BYTE_W-1:0] hour_o,
  input logic [BYTE_W-1:0] mday_o,
  input logic [BYTE_W-1:0] mon_o,
  input logic [BYTE_W-1:0] year_o,
  input logic              repaired_o,
  input logic              acc_req_o,
  input logic              acc_wr_o,
  input logic [ADDR_W-1:0] acc_addr_o,
  input logic [BYTE_W-1:0] acc_wdata_o,
  input logic              acc_done_i
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (acc_req_o)  pend_q <= 1'b1;
    else if (acc_done_i) pend_q <= 1'b0;
  end

  // R3
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o |-> !pend_q);
  // R3
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o |=> !acc_req_o);
  // R6
  sec_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && acc_wr_o && acc_addr_o == '0) |-> !acc_wdata_o[BYTE_W-1]);
  // R5
  range_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !repaired_o) |-> (sec_o <= 59 && min_o <= 59 && hour_o <= 23 &&
      mday_o >= 1 && mday_o <= 31 && mon_o >= 1 && mon_o <= 12 && year_o <= 99));
  // R7
  dflt_rep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && repaired_o) |-> (sec_o == 0 && min_o == 0 && hour_o == 0 &&
      mday_o == 1 && mon_o == 1 && year_o == 0));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(mday_o) && $stable(mon_o) && $stable(year_o) && $stable(repaired_o)));
endmodule

bind rtc_time_fetch rtcs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .mday_o(mday_o),
  .mon_o(mon_o), .year_o(year_o), .repaired_o(repaired_o),
  .acc_req_o(acc_req_o), .acc_wr_o(acc_wr_o), .acc_addr_o(acc_addr_o),
  .acc_wdata_o(acc_wdata_o), .acc_done_i(acc_done_i)
);

// File: tb/sim_rtc_time_fetch.sv
module sim_rtc_time_fetch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, repaired, req, wr, acc_done = 1'b0;
  logic [7:0] sec, mn, hr, mday, mon, yr, wdata, rdata = 8'h00;
  logic [5:0] addr;

  int tests = 0, fails = 0, viol = 0, n_done = 0, n_log = 0;
  logic [7:0] mem [0:63];
  logic [5:0] lg_addr [0:31];
  logic       lg_wr   [0:31];
  logic [7:0] lg_data [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_time_fetch u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done),
    .sec_o(sec), .min_o(mn), .hour_o(hr), .mday_o(mday), .mon_o(mon),
    .year_o(yr), .repaired_o(repaired), .acc_req_o(req), .acc_wr_o(wr),
    .acc_addr_o(addr), .acc_wdata_o(wdata), .acc_rdata_i(rdata),
    .acc_done_i(acc_done)
  );

  // serial master model with latency 0..2
  initial begin
    bit pend = 0;
    int cnt = 0, lat = 0;
    logic [5:0] pa = '0;
    forever begin
      @(negedge clk);
      acc_done = 1'b0;
      if (pend) begin
        if (req) viol++;
        if (cnt == 0) begin
          acc_done = 1'b1;
          rdata = mem[pa];
          pend = 0;
        end else cnt--;
      end else if (req) begin
        if (n_log < 32) begin
          lg_addr[n_log] = addr; lg_wr[n_log] = wr; lg_data[n_log] = wdata;
        end
        n_log++;
        if (wr) mem[addr] = wdata;
        pa = addr; pend = 1; cnt = lat; lat = (lat + 1) % 3;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) n_done++;
  end

  task automatic check(input bit ok, input string req_tag, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req_tag, msg);
    end
  endtask

  function automatic int dec(input logic [7:0] b, input bit drop);
    logic [7:0] x;
    x = drop ? (b & 8'h7f) : b;
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  task automatic run_case(input logic [7:0] b0, b1, b2, b3, b4, b5);
    int e[6];
    bit bad;
    int wait_n;
    int rd_a[6] = '{0, 1, 2, 3, 4, 6};
    int wr_a[7] = '{1, 2, 5, 3, 4, 6, 0};
    int wr_d[7] = '{0, 0, 7, 1, 1, 0, 0};
    bit log_ok;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    mem[0] = b0; mem[1] = b1; mem[2] = b2; mem[3] = b3; mem[4] = b4; mem[6] = b5;
    mem[5] = 8'h03;
    e[0] = dec(b0, 1); e[1] = dec(b1, 0); e[2] = dec(b2, 0);
    e[3] = dec(b3, 0); e[4] = dec(b4, 0); e[5] = dec(b5, 0);
    bad = e[0] > 59 || e[1] > 59 || e[2] > 23 || e[3] < 1 || e[3] > 31 ||
          e[4] < 1 || e[4] > 12 || e[5] > 99;
    if (bad) begin
      e[0] = 0; e[1] = 0; e[2] = 0; e[3] = 1; e[4] = 1; e[5] = 0;
    end
    n_log = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 300) begin
      @(negedge clk); wait_n++;
    end
    check(done == 1'b1, "R9", $sformatf("no done pulse, got %0b exp 1", done));
    check(sec == 8'(e[0]) && mn == 8'(e[1]) && hr == 8'(e[2]) && mday == 8'(e[3])
          && mon == 8'(e[4]) && yr == 8'(e[5]), bad ? "R7" : "R4",
          $sformatf("raw %h %h %h %h %h %h got %0d %0d %0d %0d %0d %0d exp %0d %0d %0d %0d %0d %0d",
            b0, b1, b2, b3, b4, b5, sec, mn, hr, mday, mon, yr, e[0], e[1], e[2], e[3], e[4], e[5]));
    check(repaired == bad, "R5", $sformatf("repaired got %0b exp %0b", repaired, bad));
    log_ok = (n_log == (bad ? 13 : 6));
    for (int i = 0; i < 6; i++)
      if (log_ok && (lg_wr[i] || lg_addr[i] != 6'(rd_a[i]))) log_ok = 0;
    if (bad)
      for (int i = 0; i < 7; i++)
        if (log_ok && (!lg_wr[6+i] || lg_addr[6+i] != 6'(wr_a[i]) || lg_data[6+i] != 8'(wr_d[i])))
          log_ok = 0;
    check(log_ok, bad ? "R6" : "R2",
          $sformatf("access log wrong, got %0d accesses exp %0d", n_log, bad ? 13 : 6));
    @(negedge clk);
    check(done == 1'b0, "R9", $sformatf("done not a pulse, got %0b exp 0", done));
  endtask

  initial begin
    #(CLK_PERIOD * 195000);
    tests++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] base [6];
    logic [7:0] v [6];
    int d0;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!done && !req && !repaired && sec == 0 && mn == 0 && hr == 0 &&
          mday == 0 && mon == 0 && yr == 0, "R1",
          $sformatf("reset state done %0b req %0b rep %0b", done, req, repaired));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!done && !req && !repaired && sec == 0 && yr == 0, "R1",
          $sformatf("idle after reset done %0b req %0b exp 0 0", done, req));

    // R4 R5 R6 R7: sweep each field over every byte, others at upper limits
    base = '{8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99};
    for (int f = 0; f < 6; f++) begin
      for (int b = 0; b < 256; b++) begin
        v = base;
        v[f] = 8'(b);
        run_case(v[0], v[1], v[2], v[3], v[4], v[5]);
      end
    end

    // R8: second start while busy is ignored
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'h10; mem[3] = 8'h15; mem[4] = 8'h06; mem[6] = 8'h24;
    n_log = 0;
    d0 = n_done;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (80) @(negedge clk);
    check(n_log == 6, "R8", $sformatf("accesses got %0d exp 6", n_log));
    check(n_done - d0 == 1, "R8", $sformatf("done pulses got %0d exp 1", n_done - d0));
    check(sec == 12 && mn == 34 && yr == 24 && !repaired, "R8",
          $sformatf("fields got %0d %0d %0d exp 12 34 24", sec, mn, yr));

    // R3: no access issued while one was outstanding
    check(viol == 0, "R3", $sformatf("overlapping requests got %0d exp 0", viol));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule